// File: doc/BRIEF.md
# DDR Column-Block Write Splitter

This block sits between a simple bus-side write port and the command and data pins of a DDR SDRAM controller. The memory runs with a fixed burst length of eight, so one WRITE covers eight 16-bit columns, which is one aligned 16-byte block. The device wraps its column address inside such a block. A bus burst that starts part-way into a block, or that runs past the end of one, would therefore land on the wrong columns if it were sent as a single WRITE. The block prevents this. It issues one WRITE per 16-byte block the burst touches, and it masks every column position that carries no bus data.

A request gives a byte address and a beat count. The 32-bit data beats, each with byte strobes, follow on a separate handshake. The block collects the beats that belong to one column block into a four-slot buffer. If the target row is not the one it last opened, it issues PRECHARGE and ACTIVATE with the programmed recovery times. It then issues the WRITE and streams four clocks of double-rate data. Both handshakes are held off while the block is working. A request that would run past the end of a row is refused: the block raises an error pulse, drains the data beats, and issues no command for them.

Top module: `ddr_wr_splitter`

## Requirements
- R1: After synchronous reset the command output is NOP (code 0), `wr_dq_en` and `err_row_cross` are low, `req_ready` is high and `wd_ready` is low.
- R2: When the target bank and row differ from the tracked open row, or no row is tracked, the block acts in this order. First, PRECHARGE (code 1) to the target bank in the cycle after the block's last beat is taken. Next, ACTIVATE (code 2) with row and bank exactly tRP cycles later. Then WRITE (code 3) exactly tRCD cycles after that. NOP is driven in every cycle between these commands. A configured delay of 0 counts as 1.
- R3: When the target bank and row equal the tracked open row, no PRECHARGE or ACTIVATE is issued. The WRITE appears in the cycle after the last beat of its block is accepted.
- R4: The byte address is laid out from the top as row bits [25:13], then bank bits [12:11], then column bits [10:1], with defaults. Each WRITE carries the column of its 16-byte block with the low three column bits zero.
- R5: A WRITE is driven in the same cycle as the first of four clocks of data. In each data clock `wr_dq_en` is high and one 32-bit slot is driven: bits [15:0] on the rising half and bits [31:16] on the falling half. The mask is the inverted strobes: `wr_dm_rise` = ~strb[1:0] and `wr_dm_fall` = ~strb[3:2]. A half whose two strobes are both 0 carries zero data.
- R6: Slots of a WRITE that come before the starting word (address bits [3:2]) or after the last beat are driven with mask 2'b11 and zero data.
- R7: A burst that touches several 16-byte blocks produces one WRITE per block. The WRITEs go to consecutive block columns (+8), with no PRECHARGE or ACTIVATE between them.
- R8: Two WRITE commands are always at least 5 clock cycles apart.
- R9: `req_ready` is high only while the block is idle. `wd_ready` is never high while `wr_dq_en` is high or together with `req_ready`.
- R10: A request whose last beat would pass the end of the row raises `err_row_cross` for exactly one cycle, in the cycle after acceptance. The block then consumes its beats, issues no command for them and leaves the tracked open row unchanged.
- R11: Every ACTIVATE records its bank and row as the tracked open row. A later request to the same bank and row is a hit. A request to any other bank or row is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trp | input | 4 | PRECHARGE-to-ACTIVATE delay in cycles (0 acts as 1) |
| cfg_trcd | input | 4 | ACTIVATE-to-WRITE delay in cycles (0 acts as 1) |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Burst request accepted when high with valid |
| req_addr | input | 26 | Start byte address (word aligned) |
| req_len | input | 4 | Beat count minus one |
| wd_valid | input | 1 | Write data beat valid |
| wd_ready | output | 1 | Write data beat accepted when high with valid |
| wd_data | input | 32 | Write data beat |
| wd_strb | input | 4 | Byte strobes of the beat |
| cmd_op | output | 2 | Command: 0 NOP, 1 PRECHARGE, 2 ACTIVATE, 3 WRITE |
| cmd_bank | output | 2 | Bank address of the command |
| cmd_row | output | 13 | Row address of ACTIVATE |
| cmd_col | output | 10 | Column address of WRITE |
| wr_dq_en | output | 1 | Data slot valid this clock |
| wr_dq_rise | output | 16 | Data of the rising-edge beat |
| wr_dq_fall | output | 16 | Data of the falling-edge beat |
| wr_dm_rise | output | 2 | Mask of the rising-edge beat |
| wr_dm_fall | output | 2 | Mask of the falling-edge beat |
| err_row_cross | output | 1 | One-cycle pulse for a refused row-crossing burst |

## Verification
The bound checker watches the command timing on every cycle. It checks that each ACTIVATE follows its PRECHARGE by the effective tRP and each WRITE after an ACTIVATE follows by tRCD, and it checks the minimum WRITE spacing. It also checks that data slots open with a WRITE, that masked halves carry zero, that intake is stalled while streaming, and that the error flag is a single-cycle pulse. The directed scenarios cover what depends on the addresses and the data. These are where each burst is cut into blocks, the column of each WRITE, which slots hold which beat under which mask, and whether a request hits or misses the tracked row. They also show that a refused burst drains its beats and leaves the open row in place.

// File: rtl/ddrws_pkg.sv
package ddrws_pkg;

    localparam int BURST_LEN  = 8;
    localparam int SLOT_COUNT = BURST_LEN / 2;
    localparam int SLOT_W     = $clog2(SLOT_COUNT);

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_WR  = 2'd3
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_PRE,
        ST_WAIT_RP,
        ST_WAIT_RCD,
        ST_STREAM,
        ST_DROP
    } seq_state_e;

    typedef struct packed {
        logic [15:0] rise;
        logic [15:0] fall;
        logic [1:0]  dm_rise;
        logic [1:0]  dm_fall;
    } ddr_slot_t;

    localparam ddr_slot_t SLOT_MASKED = '{rise: 16'h0, fall: 16'h0,
                                          dm_rise: 2'b11, dm_fall: 2'b11};

    function automatic logic [3:0] eff_delay(input logic [3:0] cfg);
        return (cfg == 4'd0) ? 4'd1 : cfg;
    endfunction

    function automatic ddr_slot_t pack_slot(input logic [31:0] data,
                                            input logic [3:0]  strb);
        ddr_slot_t s;
        s.rise    = (strb[1:0] == 2'b00) ? 16'h0 : data[15:0];
        s.fall    = (strb[3:2] == 2'b00) ? 16'h0 : data[31:16];
        s.dm_rise = ~strb[1:0];
        s.dm_fall = ~strb[3:2];
        return s;
    endfunction

endpackage

// File: rtl/ddrws_addr_map.sv
module ddrws_addr_map #(
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int LEN_W  = 4,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + 1,
    localparam int WORD_W = COL_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len_m1,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [WORD_W-1:0] word,
    output logic              crosses_row
);
    logic [WORD_W:0] last_word;

    assign word = addr[COL_W:2];
    assign bank = addr[COL_W+BANK_W:COL_W+1];
    assign row  = addr[ADDR_W-1:COL_W+BANK_W+1];

    always_comb begin
        last_word   = {1'b0, word} + (WORD_W+1)'(len_m1);
        crosses_row = last_word[WORD_W];
    end
endmodule

// File: rtl/ddrws_delay.sv
module ddrws_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ddrws_slot_buf.sv
module ddrws_slot_buf
    import ddrws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  ddr_slot_t         wr_slot,
    input  logic [SLOT_W-1:0] rd_idx,
    output ddr_slot_t         rd_slot
);
    ddr_slot_t slots [SLOT_COUNT];

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear)
                slots[g] <= SLOT_MASKED;
            else if (wr_en && (wr_idx == SLOT_W'(g)))
                slots[g] <= wr_slot;
        end
    end

    assign rd_slot = slots[rd_idx];
endmodule

// File: rtl/ddr_wr_splitter.sv
module ddr_wr_splitter
    import ddrws_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int LEN_W  = 4,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + 1,
    localparam int WORD_W = COL_W - 1,
    localparam int BLK_W  = WORD_W - SLOT_W,
    localparam int REM_W  = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trcd,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [31:0]       wd_data,
    input  logic [3:0]        wd_strb,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              wr_dq_en,
    output logic [15:0]       wr_dq_rise,
    output logic [15:0]       wr_dq_fall,
    output logic [1:0]        wr_dm_rise,
    output logic [1:0]        wr_dm_fall,
    output logic              err_row_cross
);
    seq_state_e state;

    logic [ROW_W-1:0]  dec_row;
    logic [BANK_W-1:0] dec_bank;
    logic [WORD_W-1:0] dec_word;
    logic              dec_cross;

    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic [BLK_W-1:0]  blk_q;
    logic [SLOT_W-1:0] fill_idx;
    logic [SLOT_W-1:0] out_idx;
    logic [REM_W-1:0]  remain;
    logic              need_open;
    logic              open_v;
    logic [ROW_W-1:0]  open_row;
    logic [BANK_W-1:0] open_bank;
    logic              err_q;

    logic              tmr_load;
    logic [3:0]        tmr_val;
    logic              tmr_done;

    logic              req_fire;
    logic              beat_fire;
    logic              blk_full;
    logic              blk_last;
    logic              buf_clear;
    logic [SLOT_W-1:0] rd_idx;
    ddr_slot_t         rd_slot;
    dram_cmd_e         cmd_e;

    ddrws_addr_map #(
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .LEN_W (LEN_W)
    ) u_map (
        .addr       (req_addr),
        .len_m1     (req_len),
        .row        (dec_row),
        .bank       (dec_bank),
        .word       (dec_word),
        .crosses_row(dec_cross)
    );

    ddrws_delay #(.CNT_W(4)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_done)
    );

    ddrws_slot_buf u_buf (
        .clk    (clk),
        .rst    (rst),
        .clear  (buf_clear),
        .wr_en  (beat_fire && (state == ST_GATHER)),
        .wr_idx (fill_idx),
        .wr_slot(pack_slot(wd_data, wd_strb)),
        .rd_idx (rd_idx),
        .rd_slot(rd_slot)
    );

    // handshakes and control strobes
    always_comb begin
        req_ready = (state == ST_IDLE);
        wd_ready  = (state == ST_GATHER) || (state == ST_DROP);
        req_fire  = req_valid && req_ready;
        beat_fire = wd_valid && wd_ready;
        blk_full  = (fill_idx == SLOT_W'(SLOT_COUNT - 1));
        blk_last  = (remain == REM_W'(1));
        buf_clear = (req_fire && !dec_cross) ||
                    ((state == ST_STREAM) && (out_idx == SLOT_W'(SLOT_COUNT - 1)) &&
                     (remain != '0));
        tmr_load  = (state == ST_PRE) || ((state == ST_WAIT_RP) && tmr_done);
        tmr_val   = (state == ST_PRE) ? eff_delay(cfg_trp) - 4'd1
                                      : eff_delay(cfg_trcd) - 4'd1;
    end

    // command and data outputs
    always_comb begin
        cmd_e    = CMD_NOP;
        wr_dq_en = 1'b0;
        rd_idx   = '0;
        unique case (state)
            ST_PRE:      cmd_e = CMD_PRE;
            ST_WAIT_RP:  if (tmr_done) cmd_e = CMD_ACT;
            ST_WAIT_RCD: if (tmr_done) begin
                cmd_e    = CMD_WR;
                wr_dq_en = 1'b1;
            end
            ST_STREAM: begin
                wr_dq_en = 1'b1;
                rd_idx   = out_idx;
                if (out_idx == '0) cmd_e = CMD_WR;
            end
            default: cmd_e = CMD_NOP;
        endcase
        cmd_op     = cmd_e;
        cmd_bank   = bank_q;
        cmd_row    = row_q;
        cmd_col    = {blk_q, {(COL_W - BLK_W){1'b0}}};
        wr_dq_rise = wr_dq_en ? rd_slot.rise    : 16'h0;
        wr_dq_fall = wr_dq_en ? rd_slot.fall    : 16'h0;
        wr_dm_rise = wr_dq_en ? rd_slot.dm_rise : 2'b11;
        wr_dm_fall = wr_dq_en ? rd_slot.dm_fall : 2'b11;
        err_row_cross = err_q;
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            row_q     <= '0;
            bank_q    <= '0;
            blk_q     <= '0;
            fill_idx  <= '0;
            out_idx   <= '0;
            remain    <= '0;
            need_open <= 1'b0;
            open_v    <= 1'b0;
            open_row  <= '0;
            open_bank <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_fire) begin
                    remain <= REM_W'(req_len) + REM_W'(1);
                    if (dec_cross) begin
                        err_q <= 1'b1;
                        state <= ST_DROP;
                    end else begin
                        row_q     <= dec_row;
                        bank_q    <= dec_bank;
                        blk_q     <= dec_word[WORD_W-1:SLOT_W];
                        fill_idx  <= dec_word[SLOT_W-1:0];
                        need_open <= !(open_v && (open_row == dec_row) &&
                                       (open_bank == dec_bank));
                        state     <= ST_GATHER;
                    end
                end
                ST_GATHER: if (beat_fire) begin
                    remain   <= remain - 1'b1;
                    fill_idx <= fill_idx + 1'b1;
                    if (blk_full || blk_last) begin
                        out_idx <= '0;
                        state   <= need_open ? ST_PRE : ST_STREAM;
                    end
                end
                ST_PRE: begin
                    open_v <= 1'b0;
                    state  <= ST_WAIT_RP;
                end
                ST_WAIT_RP: if (tmr_done) begin
                    open_v    <= 1'b1;
                    open_row  <= row_q;
                    open_bank <= bank_q;
                    need_open <= 1'b0;
                    state     <= ST_WAIT_RCD;
                end
                ST_WAIT_RCD: if (tmr_done) begin
                    out_idx <= SLOT_W'(1);
                    state   <= ST_STREAM;
                end
                ST_STREAM: begin
                    out_idx <= out_idx + 1'b1;
                    if (out_idx == SLOT_W'(SLOT_COUNT - 1)) begin
                        if (remain == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            blk_q    <= blk_q + 1'b1;
                            fill_idx <= '0;
                            state    <= ST_GATHER;
                        end
                    end
                end
                ST_DROP: if (beat_fire) begin
                    remain <= remain - 1'b1;
                    if (blk_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ddrws_checker.sv
module ddrws_checker
    import ddrws_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cfg_trp,
    input logic [3:0]  cfg_trcd,
    input logic        req_ready,
    input logic        wd_ready,
    input logic [1:0]  cmd_op,
    input logic        wr_dq_en,
    input logic [15:0] wr_dq_rise,
    input logic [15:0] wr_dq_fall,
    input logic [1:0]  wr_dm_rise,
    input logic [1:0]  wr_dm_fall,
    input logic        err_row_cross
);
    logic [1:0] last_op;
    logic [4:0] since_pre;
    logic [4:0] since_act;
    logic [4:0] since_wr;
    logic       seen_wr;

    function automatic logic [4:0] sat_inc(input logic [4:0] v);
        return (v == 5'd31) ? v : v + 5'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op   <= CMD_NOP;
            since_pre <= '0;
            since_act <= '0;
            since_wr  <= '0;
            seen_wr   <= 1'b0;
        end else begin
            if (cmd_op != CMD_NOP) last_op <= cmd_op;
            since_pre <= (cmd_op == CMD_PRE) ? 5'd1 : sat_inc(since_pre);
            since_act <= (cmd_op == CMD_ACT) ? 5'd1 : sat_inc(since_act);
            since_wr  <= (cmd_op == CMD_WR)  ? 5'd1 : sat_inc(since_wr);
            if (cmd_op == CMD_WR) seen_wr <= 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cmd_op == CMD_NOP) && !wr_dq_en && req_ready && !err_row_cross);

    a_r2_act_after_trp: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_ACT) |-> (last_op == CMD_PRE) &&
                                (since_pre == {1'b0, eff_delay(cfg_trp)}));

    a_r2_wr_after_trcd: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_WR) && (last_op == CMD_ACT) |->
            (since_act == {1'b0, eff_delay(cfg_trcd)}));

    a_r8_write_spacing: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_WR) && seen_wr |-> (since_wr >= 5'd5));

    a_r5_data_opens_with_write: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_dq_en) |-> (cmd_op == CMD_WR));

    a_r5_write_carries_data: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_WR) |-> wr_dq_en);

    a_r6_masked_rise_zero: assert property (@(posedge clk) disable iff (rst)
        wr_dq_en && (wr_dm_rise == 2'b11) |-> (wr_dq_rise == 16'h0));

    a_r6_masked_fall_zero: assert property (@(posedge clk) disable iff (rst)
        wr_dq_en && (wr_dm_fall == 2'b11) |-> (wr_dq_fall == 16'h0));

    a_r9_no_intake_streaming: assert property (@(posedge clk) disable iff (rst)
        wr_dq_en |-> !wd_ready);

    a_r9_one_side_ready: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && wd_ready));

    a_r10_err_single_pulse: assert property (@(posedge clk) disable iff (rst)
        err_row_cross |=> !err_row_cross);

    a_r10_err_no_command: assert property (@(posedge clk) disable iff (rst)
        err_row_cross |-> (cmd_op == CMD_NOP));
endmodule

bind ddr_wr_splitter ddrws_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_trp      (cfg_trp),
    .cfg_trcd     (cfg_trcd),
    .req_ready    (req_ready),
    .wd_ready     (wd_ready),
    .cmd_op       (cmd_op),
    .wr_dq_en     (wr_dq_en),
    .wr_dq_rise   (wr_dq_rise),
    .wr_dq_fall   (wr_dq_fall),
    .wr_dm_rise   (wr_dm_rise),
    .wr_dm_fall   (wr_dm_fall),
    .err_row_cross(err_row_cross)
);

// File: tb/tb_ddr_wr_splitter.sv
`timescale 1ns/1ps
module tb_ddr_wr_splitter;
    localparam int COL_W  = 10;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;
    localparam int LEN_W  = 4;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + 1;
    localparam int LOG_N  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        cfg_trp = 4'd2;
    logic [3:0]        cfg_trcd = 4'd2;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              wd_valid = 1'b0;
    logic              wd_ready;
    logic [31:0]       wd_data = '0;
    logic [3:0]        wd_strb = '0;
    logic [1:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic              wr_dq_en;
    logic [15:0]       wr_dq_rise, wr_dq_fall;
    logic [1:0]        wr_dm_rise, wr_dm_fall;
    logic              err_row_cross;

    ddr_wr_splitter dut (.*);

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int scen = 0;

    int   n_cmd, n_dat, n_acc, n_err, n_stall_bad;
    int   c_cyc [LOG_N];
    logic [1:0] c_op [LOG_N];
    int   c_bank [LOG_N], c_row [LOG_N], c_col [LOG_N];
    logic [15:0] d_rise [LOG_N], d_fall [LOG_N];
    logic [1:0]  d_dmr [LOG_N], d_dmf [LOG_N];
    int   a_cyc [LOG_N];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        if (cmd_op != 2'd0 && n_cmd < LOG_N) begin
            c_cyc[n_cmd] = cyc; c_op[n_cmd] = cmd_op;
            c_bank[n_cmd] = int'(cmd_bank); c_row[n_cmd] = int'(cmd_row);
            c_col[n_cmd] = int'(cmd_col);
            n_cmd++;
        end
        if (wr_dq_en && n_dat < LOG_N) begin
            d_rise[n_dat] = wr_dq_rise; d_fall[n_dat] = wr_dq_fall;
            d_dmr[n_dat] = wr_dm_rise; d_dmf[n_dat] = wr_dm_fall;
            n_dat++;
        end
        if (wd_valid && wd_ready && n_acc < LOG_N) begin
            a_cyc[n_acc] = cyc; n_acc++;
        end
        if (err_row_cross) n_err++;
        if (wr_dq_en && wd_ready) n_stall_bad++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] strb_for(input int mode, input int i);
        if (mode == 0) return 4'hF;
        case (i % 3)
            0: return 4'b0011;
            1: return 4'b1100;
            default: return 4'b0110;
        endcase
    endfunction

    function automatic logic [31:0] data_for(input int i);
        return 32'hC0DE_0000 + 32'(scen << 8) + 32'(i) + 32'h0101_0000 * 32'(i);
    endfunction

    function automatic int eff(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // Drives one burst and compares every command and data slot to the model.
    task automatic run_burst(input int row, input int bank, input int off, input int n,
                             input int smode, input bit exp_miss, input bit exp_err);
        logic [ADDR_W-1:0] a;
        int w0, b_first, b_last, nb, ci, di;
        scen++;
        n_cmd = 0; n_dat = 0; n_acc = 0; n_err = 0;
        a = {ROW_W'(row), BANK_W'(bank), (COL_W+1)'(off)};
        w0 = off / 4;
        b_first = w0 / 4;
        b_last  = (w0 + n - 1) / 4;
        nb = b_last - b_first + 1;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(n - 1);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready, "R9", "req_ready while busy", req_ready, 0);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wd_valid = 1'b1; wd_data = data_for(i); wd_strb = strb_for(smode, i);
            do @(negedge clk); while (!wd_ready);
        end
        @(posedge clk); #1;
        wd_valid = 1'b0;
        do @(negedge clk); while (!req_ready);
        repeat (2) @(negedge clk);

        chk(n_acc == n, "R10", "beats consumed", n_acc, n);
        if (exp_err) begin
            chk(n_err == 1, "R10", "error pulse count", n_err, 1);
            chk(n_cmd == 0, "R10", "commands on refused burst", n_cmd, 0);
            chk(n_dat == 0, "R10", "data on refused burst", n_dat, 0);
            return;
        end
        chk(n_err == 0, "R10", "spurious error", n_err, 0);
        chk(n_cmd == nb + (exp_miss ? 2 : 0), "R7", "command count",
            n_cmd, nb + (exp_miss ? 2 : 0));
        chk(n_dat == 4 * nb, "R5", "data slot count", n_dat, 4 * nb);
        if (n_cmd != nb + (exp_miss ? 2 : 0) || n_dat != 4 * nb) return;
        ci = 0;
        if (exp_miss) begin
            int g0 = a_cyc[((b_first * 4 + 3 < w0 + n - 1) ? b_first * 4 + 3 : w0 + n - 1) - w0];
            chk(c_op[0] == 2'd1 && c_bank[0] == bank, "R2", "precharge op/bank", c_op[0], 1);
            chk(c_cyc[0] == g0 + 1, "R2", "precharge cycle", c_cyc[0], g0 + 1);
            chk(c_op[1] == 2'd2 && c_row[1] == row && c_bank[1] == bank,
                "R2", "activate op/row", c_row[1], row);
            chk(c_cyc[1] - c_cyc[0] == eff(cfg_trp), "R2", "tRP gap",
                c_cyc[1] - c_cyc[0], eff(cfg_trp));
            chk(c_cyc[2] - c_cyc[1] == eff(cfg_trcd), "R2", "tRCD gap",
                c_cyc[2] - c_cyc[1], eff(cfg_trcd));
            ci = 2;
        end
        for (int b = b_first; b <= b_last; b++) begin
            int lastw = (b * 4 + 3 < w0 + n - 1) ? b * 4 + 3 : w0 + n - 1;
            chk(c_op[ci] == 2'd3, "R7", "write op", c_op[ci], 3);
            chk(c_col[ci] == b * 8 && c_bank[ci] == bank, "R4", "write column",
                c_col[ci], b * 8);
            if (!(exp_miss && b == b_first))
                chk(c_cyc[ci] == a_cyc[lastw - w0] + 1, "R3", "write after last beat",
                    c_cyc[ci], a_cyc[lastw - w0] + 1);
            if (b > b_first)
                chk(c_cyc[ci] - c_cyc[ci - 1] >= 5, "R8", "write spacing",
                    c_cyc[ci] - c_cyc[ci - 1], 5);
            for (int j = 0; j < 4; j++) begin
                int w = b * 4 + j;
                logic [15:0] er, ef;
                logic [1:0] mr, mf;
                di = (b - b_first) * 4 + j;
                if (w >= w0 && w < w0 + n) begin
                    logic [3:0] s = strb_for(smode, w - w0);
                    logic [31:0] d = data_for(w - w0);
                    mr = ~s[1:0]; mf = ~s[3:2];
                    er = (s[1:0] == 0) ? 16'h0 : d[15:0];
                    ef = (s[3:2] == 0) ? 16'h0 : d[31:16];
                    chk({d_rise[di], d_fall[di], d_dmr[di], d_dmf[di]} == {er, ef, mr, mf},
                        "R5", "data slot", {d_rise[di], d_fall[di], d_dmr[di], d_dmf[di]},
                        {er, ef, mr, mf});
                end else begin
                    chk({d_rise[di], d_fall[di], d_dmr[di], d_dmf[di]} == {32'h0, 4'hF},
                        "R6", "masked slot", {d_rise[di], d_fall[di], d_dmr[di], d_dmf[di]},
                        {32'h0, 4'hF});
                end
            end
            ci++;
        end
        chk(n_stall_bad == 0, "R9", "intake during stream", n_stall_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(cmd_op == 2'd0, "R1", "reset command", cmd_op, 0);
        chk(!wr_dq_en && !err_row_cross, "R1", "reset data/err", {wr_dq_en, err_row_cross}, 0);
        chk(req_ready && !wd_ready, "R1", "reset readies", {req_ready, wd_ready}, 2'b10);
    endtask

    task automatic t_first_miss;   // R2 R4 R11: nothing open yet
        cfg_trp = 4'd2; cfg_trcd = 4'd2;
        run_burst(5, 1, 'h40, 4, 0, 1'b1, 1'b0);
    endtask

    task automatic t_hit_single;   // R3 R6: one beat in slot 2, partial strobes
        run_burst(5, 1, 'h48, 1, 1, 1'b0, 1'b0);
    endtask

    task automatic t_split_two;    // R7 R8: 4 beats from 0x0C
        run_burst(5, 1, 'h0C, 4, 0, 1'b0, 1'b0);
    endtask

    task automatic t_long_split;   // R7: 16 beats from 0x14, five blocks
        run_burst(5, 1, 'h14, 16, 1, 1'b0, 1'b0);
    endtask

    task automatic t_other_bank;   // R11: same row, other bank misses
        cfg_trp = 4'd3; cfg_trcd = 4'd1;
        run_burst(5, 2, 'h00, 2, 0, 1'b1, 1'b0);
    endtask

    task automatic t_zero_delay;   // R2: 0 acts as 1; R11: other row misses
        cfg_trp = 4'd0; cfg_trcd = 4'd4;
        run_burst(9, 2, 'h1F0, 3, 1, 1'b1, 1'b0);
    endtask

    task automatic t_row_cross;    // R10: refused, open row kept (next is a hit)
        run_burst(9, 2, (1 << (COL_W + 1)) - 4, 2, 0, 1'b0, 1'b1);
        run_burst(9, 2, 'h08, 1, 0, 1'b0, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_first_miss();
        t_hit_single();
        t_split_two();
        t_long_split();
        t_other_bank();
        t_zero_delay();
        t_row_cross();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule